// File: doc/BRIEF.md
# GPIO Input Qualification Filter

This block conditions asynchronous pad inputs before the core sees them. Each pin runs in one of four modes, set by its own 2-bit code. It can be resynchronised to the system clock only. It can be qualified by a short or a long run of agreeing samples, so that glitches shorter than the window are rejected. Or it can bypass all conditioning, for peripheral inputs that do their own sampling.

The pins are split into groups of eight. Each group has an 8-bit period field and its own sample tick counter. With a field value P, samples are taken every 2·P system clocks. A value of zero samples on every clock, and 0x80 spaces the samples 256 clocks apart. A pin in a qualifying mode only changes its output when every sample in its window shows the same new level. Otherwise the output holds its last value.

Top module: `gpio_qual_filter`

## Requirements
- R1: Mode code 2'b00 (sync): the output register follows the pin through a two-flop synchroniser. A pin change driven between clock edges appears on the output after the third rising edge, and not after the second.
- R2: Mode code 2'b11 (bypass): the output equals the raw pin combinationally, with no clock delay.
- R3: Each group takes a sample every 2·P clocks, where P is its 8-bit period field. P = 0 means every clock, and P = 0x80 means every 256 clocks.
- R4: Mode code 2'b01 (three-sample): the output takes a new level only when three consecutive samples agree. A pulse lasting at most 2 sample spacings is rejected, and one lasting at least 3 spacings is passed.
- R5: Mode code 2'b10 (six-sample): the output takes a new level only when six consecutive samples agree. A pulse lasting at most 5 spacings is rejected, and one lasting at least 6 spacings is passed.
- R6: In the qualifying modes the output holds its previous level unless the window agrees. When the output changes, its new value is the synchronised pin level. A disagreeing glitch leaves a settled output unchanged.
- R7: While reset is asserted, every non-bypass output is 0 and the sample history is cleared.
- R8: Pins 0–7 use the period field in bits 7:0 and pins 8–15 use bits 15:8. Each group's spacing is independent of the other group's field.
- R9: Each pin's mode field, at bits 2p+1:2p, acts on that pin alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pad_i | input | 16 | Raw asynchronous pin levels |
| period_i | input | 16 | Per-group sample period fields, 8 bits per group |
| mode_i | input | 32 | Per-pin 2-bit conditioning mode |
| qual_o | output | 16 | Conditioned pin levels to the core |

## Verification
The assertions assume that reset is released away from a clock edge, and that pad, mode and period inputs change only between rising edges. They also assume that a pin's mode is steady over the cycles in which its output is compared with the pin level three edges earlier. The stimulus meets these assumptions: it drives every input on falling edges and holds each configuration for a full settling interval before it pulses the pins. Pulse lengths sit exactly on the accept and reject boundaries of each window. This keeps the pass or reject outcome independent of the unknown tick phase.

// File: rtl/gpio_qual_pkg.sv
package gpio_qual_pkg;
  typedef enum logic [1:0] {
    QM_SYNC  = 2'b00,
    QM_QUAL3 = 2'b01,
    QM_QUAL6 = 2'b10,
    QM_ASYNC = 2'b11
  } qual_mode_e;
endpackage

// File: rtl/gpio_qual_tick.sv
module gpio_qual_tick #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  localparam int CNT_W = PER_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             last;

  always_comb begin
    lim   = {period_i, 1'b0} - CNT_W'(1);
    last  = (period_i == '0) || (cnt_q >= lim);
    cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = last;
endmodule

// File: rtl/gpio_qual_sync.sv
module gpio_qual_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/gpio_qual_lane.sv
module gpio_qual_lane
  import gpio_qual_pkg::*;
#(
  parameter int SHORT_N = 3,
  parameter int LONG_N  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       sync_i,
  input  logic       pad_i,
  input  qual_mode_e mode_i,
  output logic       q_o
);
  localparam int HIST_W = LONG_N - 1;

  logic [HIST_W-1:0]  hist_q, hist_d;
  logic [SHORT_N-1:0] win_short;
  logic [LONG_N-1:0]  win_long;
  logic               agree_short, agree_long;
  logic               q_q, q_d;

  always_comb begin
    win_short   = {hist_q[SHORT_N-2:0], sync_i};
    win_long    = {hist_q, sync_i};
    agree_short = (&win_short) | ~(|win_short);
    agree_long  = (&win_long)  | ~(|win_long);
    hist_d      = tick_i ? {hist_q[HIST_W-2:0], sync_i} : hist_q;
    unique case (mode_i)
      QM_QUAL3: q_d = (tick_i && agree_short) ? sync_i : q_q;
      QM_QUAL6: q_d = (tick_i && agree_long)  ? sync_i : q_q;
      default:  q_d = sync_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      q_q    <= 1'b0;
    end else begin
      hist_q <= hist_d;
      q_q    <= q_d;
    end
  end

  assign q_o = (mode_i == QM_ASYNC) ? pad_i : q_q;
endmodule

// File: rtl/gpio_qual_filter.sv
module gpio_qual_filter
  import gpio_qual_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int GROUP_PINS = 8,
  parameter int PER_W      = 8,
  parameter int SHORT_N    = 3,
  parameter int LONG_N     = 6,
  localparam int NUM_GROUPS = (NUM_PINS + GROUP_PINS - 1) / GROUP_PINS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         pad_i,
  input  logic [NUM_GROUPS*PER_W-1:0] period_i,
  input  logic [2*NUM_PINS-1:0]       mode_i,
  output logic [NUM_PINS-1:0]         qual_o
);
  logic [NUM_PINS-1:0]   pad_sync;
  logic [NUM_GROUPS-1:0] grp_tick;

  gpio_qual_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pad_i),
    .sync_o  (pad_sync)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    gpio_qual_tick #(.PER_W(PER_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .period_i (period_i[g*PER_W +: PER_W]),
      .tick_o   (grp_tick[g])
    );
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_qual_lane #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (grp_tick[p / GROUP_PINS]),
      .sync_i (pad_sync[p]),
      .pad_i  (pad_i[p]),
      .mode_i (qual_mode_e'(mode_i[2*p +: 2])),
      .q_o    (qual_o[p])
    );
  end
endmodule

// File: rtl/gpio_qual_checker.sv
module gpio_qual_checker
  import gpio_qual_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PINS-1:0]   pad_i,
  input logic [2*NUM_PINS-1:0] mode_i,
  input logic [NUM_PINS-1:0]   qual_o
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd3);

  AST_NO_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(qual_o)); // R7

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    logic [1:0] md;
    assign md = mode_i[2*p +: 2];

    AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(md) == QM_SYNC && md != QM_ASYNC)
      |-> qual_o[p] == $past(pad_i[p], 3)); // R1

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (md == QM_ASYNC) |-> qual_o[p] == pad_i[p]); // R2

    AST_QUAL_TAKES_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && ($past(md) == QM_QUAL3 || $past(md) == QM_QUAL6)
       && $past(md, 2) != QM_ASYNC && md != QM_ASYNC
       && qual_o[p] != $past(qual_o[p]))
      |-> qual_o[p] == $past(pad_i[p], 3)); // R6

    always @(posedge clk) begin
      if (!rst_n && md != QM_ASYNC)
        AST_RESET_CLEAR: assert (qual_o[p] == 1'b0); // R7
    end
  end
endmodule

bind gpio_qual_filter gpio_qual_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pad_i  (pad_i),
  .mode_i (mode_i),
  .qual_o (qual_o)
);

// File: tb/test_gpio_qual_filter.sv
module test_gpio_qual_filter;
  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  p0;
    logic [7:0]  p1;
    logic [11:0] len;
    logic        e0;
    logic        e1;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  // mode codes: 00 sync, 01 three-sample, 10 six-sample, 11 bypass
  localparam vec_t VECS [NV] = '{
    '{2'b00, 8'h00, 8'h00, 12'd1,   1'b1, 1'b1, 4'd1}, // R1 one-cycle pulse passes
    '{2'b11, 8'h00, 8'h00, 12'd1,   1'b1, 1'b1, 4'd2}, // R2 bypass
    '{2'b01, 8'h00, 8'h00, 12'd2,   1'b0, 1'b0, 4'd4}, // R4 reject at 2 spacings
    '{2'b01, 8'h00, 8'h00, 12'd3,   1'b1, 1'b1, 4'd4}, // R4 accept at 3
    '{2'b10, 8'h00, 8'h00, 12'd5,   1'b0, 1'b0, 4'd5}, // R5 reject at 5
    '{2'b10, 8'h00, 8'h00, 12'd6,   1'b1, 1'b1, 4'd5}, // R5 accept at 6
    '{2'b01, 8'h02, 8'h02, 12'd8,   1'b0, 1'b0, 4'd3}, // R3 spacing 4, reject
    '{2'b01, 8'h02, 8'h02, 12'd12,  1'b1, 1'b1, 4'd3}, // R3 spacing 4, accept
    '{2'b10, 8'h02, 8'h02, 12'd20,  1'b0, 1'b0, 4'd5}, // R5 spacing 4, reject
    '{2'b10, 8'h02, 8'h02, 12'd24,  1'b1, 1'b1, 4'd5}, // R5 spacing 4, accept
    '{2'b01, 8'h80, 8'h80, 12'd512, 1'b0, 1'b0, 4'd3}, // R3 0x80 -> 256 clocks
    '{2'b01, 8'h80, 8'h00, 12'd768, 1'b1, 1'b1, 4'd3}, // R3 0x80 accept
    '{2'b01, 8'h00, 8'h80, 12'd3,   1'b1, 1'b0, 4'd8}, // R8 groups independent
    '{2'b10, 8'h01, 8'h03, 12'd12,  1'b1, 1'b0, 4'd8}  // R8 spacing 2 vs 6
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pad_i;
  logic [15:0] period_i;
  logic [31:0] mode_i;
  logic [15:0] qual_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] hi_seen, lo_seen;

  always #4 clk = ~clk;

  gpio_qual_filter i_gpio_qual_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_i    (pad_i),
    .period_i (period_i),
    .mode_i   (mode_i),
    .qual_o   (qual_o)
  );

  always @(negedge clk) begin
    #1;
    hi_seen = hi_seen | qual_o;
    lo_seen = lo_seen | ~qual_o;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pad_i = '0; period_i = '0; mode_i = '0;
    hi_seen = '0; lo_seen = '0;
    repeat (3) @(negedge clk);
    #1 chk(qual_o == 16'h0, "R7 reset", qual_o, 16'h0);
    pad_i = '1;
    @(negedge clk); #1 chk(qual_o == 16'h0, "R7 reset holds", qual_o, 16'h0);
    pad_i = '0;
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int   t, w;
      v = VECS[i];
      pad_i = '0; mode_i = {16{v.mode}}; period_i = {v.p1, v.p0};
      t = 2 * ((v.p0 > v.p1) ? int'(v.p0) : int'(v.p1));
      if (t == 0) t = 1;
      w = 6 * t + 10;
      repeat (w) @(negedge clk);
      hi_seen = '0;
      pad_i = '1;
      repeat (int'(v.len)) @(negedge clk);
      pad_i = '0;
      repeat (w) @(negedge clk);
      chk(hi_seen == {{8{v.e1}}, {8{v.e0}}}, $sformatf("R%0d vector %0d", v.req, i),
          hi_seen, {{8{v.e1}}, {8{v.e0}}});
      #1 chk(qual_o == 16'h0, "R6 settles low", qual_o, 16'h0);
    end

    // R1 latency: pad changes between edges, output after third edge
    @(negedge clk); mode_i = '0; period_i = '0; repeat (4) @(negedge clk);
    pad_i = 16'h0001;
    repeat (2) @(negedge clk);
    #1 chk(qual_o[0] == 1'b0, "R1 not after two edges", qual_o, 16'h0);
    @(negedge clk);
    #1 chk(qual_o[0] == 1'b1, "R1 after third edge", qual_o, 16'h1);
    pad_i = '0; repeat (4) @(negedge clk);

    // R9 per-pin mode: pin0 bypass, pin1 sync
    mode_i = 32'h0000_0003; @(negedge clk);
    pad_i = 16'h0003; #1;
    chk(qual_o[1:0] == 2'b01, "R9 pin modes independent", qual_o, 16'h1);
    repeat (3) @(negedge clk);
    #1 chk(qual_o[1:0] == 2'b11, "R9 sync pin follows", qual_o, 16'h3);
    pad_i = '0; mode_i = '0; repeat (4) @(negedge clk);

    // R6 hold: three-sample mode, glitch low of two samples ignored
    mode_i = {16{2'b01}}; period_i = '0;
    pad_i = '1; repeat (10) @(negedge clk);
    #1 chk(qual_o == 16'hFFFF, "R6 settled high", qual_o, 16'hFFFF);
    lo_seen = '0;
    pad_i = '0; repeat (2) @(negedge clk);
    pad_i = '1; repeat (10) @(negedge clk);
    chk(lo_seen == 16'h0, "R6 glitch held", lo_seen, 16'h0);

    // R7 mid-run reset clears outputs at once
    mode_i = '0; repeat (4) @(negedge clk);
    rst_n = 1'b0; #1;
    chk(qual_o == 16'h0, "R7 async clear", qual_o, 16'h0);
    pad_i = '0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk(qual_o == 16'h0, "R7 after release", qual_o, 16'h0);

    finish_run();
  end
endmodule